// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a flash memory model and takes over read data while an internal program or erase runs. The command decoder gives it a one-cycle start pulse, the operation type and the data word just loaded. The block times the operation with a cycle counter whose length is a parameter for each type. It drives an active-low busy output, in open-drain style, for the whole operation.

While the operation runs, a read returns two independent completion indicators in place of two array bits. Bit 7 depends on the operation type: for a program it is the inverse of bit 7 of the loaded word, and for an erase it is 0. Bit 6 changes on every new read access. A host can poll either bit, or watch the busy line, and may begin at any time after the start. Once the counter expires, reads return plain array data again.

A read access is active when the chip-enable and output-enable inputs are both low. A new access begins in the cycle where the combined strobe turns active after a cycle in which it was not.

Top module: `opstat_reporter`

## Requirements
- R1: While `ceN` or `oeN` is high, `rdData` is all zeros; a read is active only when both are low.
- R2: While `busyN` is high and a read is active, `rdData` equals `arrayData`.
- R3: A high `opStart` at a rising clock edge with `busyN` high starts an operation. `busyN` is low from that edge for exactly `PROG_CYCLES` cycles when `opIsErase` is 0, or `ERASE_CYCLES` cycles when it is 1, and then goes high.
- R4: During a program operation (`opIsErase`=0), a read returns in bit 7 the inverse of bit 7 of the `loadData` word captured at the start.
- R5: During an erase operation (`opIsErase`=1), a read returns 0 in bit 7.
- R6: During any operation, a read returns in bit 6 a toggle flag. The flag inverts at each clock edge where busy is set and a read access begins (strobe active now, inactive in the previous cycle). Successive reads therefore show opposite values.
- R7: During an operation, every `rdData` bit other than 7 and 6 equals the same bit of `arrayData`.
- R8: A start pulse received while `busyN` is low is ignored: the running operation keeps its length, its type and its captured bit.
- R9: A low `rstN` at once forces `busyN` high and clears the toggle flag to 0, so the first read of the next operation shows 1 in bit 6.
- R10: After `busyN` goes high, bit 6 stops changing and successive reads return the unchanged array word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opStart | input | 1 | One-cycle pulse from the command decoder that starts an operation |
| opIsErase | input | 1 | Operation type at start: 0 program, 1 erase |
| loadData | input | DW | Data word just loaded for a program |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| arrayData | input | DW | Word read from the storage array |
| rdData | output | DW | Read data returned to the host |
| busyN | output | 1 | Ready/busy, low while an operation runs |

## Verification
A stuck or miscounted duration counter appears on `busyN` as a release that comes early or late by a whole number of cycles. It is seen at the first edge after the expected release. A wrong captured type or loaded bit corrupts bit 7 on the first read made after the start. A toggle flag that skips a flip or flips twice shows up as two successive reads with equal bit 6. A flag that is not cleared by reset shows up as the wrong value on the first read after reset.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  // bit positions the host decodes while an operation runs
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch the loaded word this edge
    logic busy;        // operation in flight
    logic isErase;     // type of the running operation
    logic flipToggle;  // invert the toggle flag this edge
  } opCtl_t;
endpackage

// File: rtl/opstat_ctrl.sv
module opstat_ctrl
  import opstat_pkg::*;
#(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 50
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   opStart,
  input  logic   opIsErase,
  input  logic   ceN,
  input  logic   oeN,
  output opCtl_t ctl,
  output logic   readAct
);
  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(1);

  logic             busyQ;
  logic             eraseQ;
  logic             prevAct;
  logic [CNT_W-1:0] cntQ;

  assign readAct = ~ceN & ~oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      eraseQ  <= 1'b0;
      prevAct <= 1'b0;
      cntQ    <= '0;
    end else begin
      prevAct <= readAct;
      if (busyQ) begin
        if (cntQ == LAST_CNT) busyQ <= 1'b0;
        cntQ <= cntQ - LAST_CNT;
      end else if (opStart) begin
        busyQ  <= 1'b1;
        eraseQ <= opIsErase;
        cntQ   <= opIsErase ? ERASE_LOAD : PROG_LOAD;
      end
    end
  end

  always_comb begin
    ctl.capture    = opStart & ~busyQ;
    ctl.busy       = busyQ;
    ctl.isErase    = eraseQ;
    ctl.flipToggle = busyQ & readAct & ~prevAct;
  end
endmodule

// File: rtl/opstat_datapath.sv
module opstat_datapath
  import opstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  opCtl_t        ctl,
  input  logic          readAct,
  input  logic [DW-1:0] loadData,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] ldQ;
  logic          togQ;
  logic [DW-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldQ  <= '0;
      togQ <= 1'b0;
    end else begin
      if (ctl.capture)    ldQ  <= loadData;
      if (ctl.flipToggle) togQ <= ~togQ;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign statusWord[i] = ctl.isErase ? 1'b0 : ~ldQ[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign statusWord[i] = togQ;
    end else begin : g_pass
      assign statusWord[i] = arrayData[i];
    end
  end

  always_comb begin
    if (!readAct)      rdData = '0;
    else if (ctl.busy) rdData = statusWord;
    else               rdData = arrayData;
  end
endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
  import opstat_pkg::*;
#(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 50
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opStart,
  input  logic          opIsErase,
  input  logic [DW-1:0] loadData,
  input  logic          ceN,
  input  logic          oeN,
  input  logic [DW-1:0] arrayData,
  output logic [DW-1:0] rdData,
  output logic          busyN
);
  opCtl_t ctl;
  logic   readAct;

  opstat_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opStart  (opStart),
    .opIsErase(opIsErase),
    .ceN      (ceN),
    .oeN      (oeN),
    .ctl      (ctl),
    .readAct  (readAct)
  );

  opstat_datapath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .readAct  (readAct),
    .loadData (loadData),
    .arrayData(arrayData),
    .rdData   (rdData)
  );

  assign busyN = ~ctl.busy;
endmodule

// File: rtl/opstat_reporter_chk.sv
module opstat_reporter_chk #(
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 50
) (
  input logic          clk,
  input logic          rstN,
  input logic          opStart,
  input logic          opIsErase,
  input logic [DW-1:0] loadData,
  input logic          ceN,
  input logic          oeN,
  input logic [DW-1:0] arrayData,
  input logic [DW-1:0] rdData,
  input logic          busyN
);
  localparam logic [DW-1:0] KEEP_MASK = ~((DW'(1) << 7) | (DW'(1) << 6));

  logic          rdAct;
  logic          prevActC;
  logic          chkErase;
  logic [DW-1:0] chkLoad;
  int            chkLen;
  int            chkCnt;

  assign rdAct = ~ceN & ~oeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActC <= 1'b0;
      chkErase <= 1'b0;
      chkLoad  <= '0;
      chkLen   <= 0;
      chkCnt   <= 0;
    end else begin
      prevActC <= rdAct;
      if (opStart && busyN) begin
        chkErase <= opIsErase;
        chkLoad  <= loadData;
        chkLen   <= opIsErase ? ERASE_CYCLES : PROG_CYCLES;
        chkCnt   <= 0;
      end else if (!busyN) begin
        chkCnt <= chkCnt + 1;
      end
    end
  end

  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdAct |-> rdData == '0);

  a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && rdAct) |-> rdData == arrayData);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> chkCnt == chkLen);

  a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && rdAct && !chkErase) |-> rdData[7] == ~chkLoad[7]);

  a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && rdAct && chkErase) |-> rdData[7] == 1'b0);

  a_r6_toggle_flip: assert property (@(posedge clk) disable iff (!rstN)
    (rdAct && !prevActC && !busyN) |=> (!rdAct || busyN || rdData[6] != $past(rdData[6])));

  a_r7_other_bits: assert property (@(posedge clk) disable iff (!rstN)
    (!busyN && rdAct) |-> (rdData & KEEP_MASK) == (arrayData & KEEP_MASK));

  a_r10_settled: assert property (@(posedge clk) disable iff (!rstN)
    (busyN && $past(busyN) && rdAct && $past(rdAct) && $stable(arrayData)) |-> $stable(rdData));

  always @(posedge clk) begin
    if (!rstN) begin
      a_r9_reset_idle: assert (busyN);
    end
  end
endmodule

bind opstat_reporter opstat_reporter_chk #(
  .DW(DW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (.*);

// File: tb/tb_opstat_reporter.sv
module tb_opstat_reporter;
  localparam int DW = 8;
  localparam int PC = 20;
  localparam int EC = 50;
  localparam int NVEC = 6;
  // fields: [20] erase, [19:12] loaded word, [11:4] array word, [3:0] reads during busy
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 8'h5A, 8'h3C, 4'd3},
    {1'b0, 8'hA5, 8'hFF, 4'd4},
    {1'b1, 8'h80, 8'h81, 4'd2},
    {1'b1, 8'h00, 8'h7E, 4'd5},
    {1'b0, 8'hFF, 8'h00, 4'd1},
    {1'b0, 8'h00, 8'hC3, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic opStart = 1'b0, opIsErase = 1'b0, ceN = 1'b1, oeN = 1'b1;
  logic [DW-1:0] loadData = '0, arrayData = '0;
  logic [DW-1:0] rdData;
  logic busyN;

  int checks = 0, fails = 0, busyCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  opstat_reporter #(.DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (.*);

  // behavioural model of the requirements
  logic mBusy = 1'b0, mErase = 1'b0, mPol = 1'b0, mTog = 1'b0, mPrev = 1'b0;
  int   mRem = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 1'b0; mTog <= 1'b0; mPrev <= 1'b0;
    end else begin
      mPrev <= ~ceN & ~oeN;
      if (mBusy && !ceN && !oeN && !mPrev) mTog <= ~mTog;            // R6
      if (mBusy) begin
        if (mRem == 1) mBusy <= 1'b0;
        mRem <= mRem - 1;
      end else if (opStart) begin                                      // R3
        mBusy <= 1'b1; mErase <= opIsErase; mPol <= ~loadData[7];
        mRem <= opIsErase ? EC : PC;
      end
    end
  end

  always @(negedge clk) if (!busyN) busyCnt++;

  function automatic logic [DW-1:0] expRead();
    logic [DW-1:0] w;
    if (ceN || oeN) return '0;
    w = arrayData;
    if (mBusy) begin
      w[7] = mErase ? 1'b0 : mPol;
      w[6] = mTog;
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic startOp(input logic er, input logic [DW-1:0] ld);
    opStart = 1'b1; opIsErase = er; loadData = ld;
    busyCnt = 0;
    @(posedge clk); @(negedge clk);
    opStart = 1'b0;
  endtask

  task automatic readChk(input string tag);
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    check(tag, rdData, expRead());
    ceN = 1'b1; oeN = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic waitIdle();
    while (!busyN) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic b6;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset busy", {7'd0, busyN}, 8'd1);
    check("R1 idle no read", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [20:0] e;
      e = VEC[v];
      arrayData = e[11:4];
      startOp(e[20], e[19:12]);
      for (int r = 0; r < int'(e[3:0]); r++)
        readChk(e[20] ? "R5/R6/R7 erase status" : "R4/R6/R7 program status");
      waitIdle();
      check("R3 busy length", 8'(busyCnt), e[20] ? 8'(EC) : 8'(PC));
      readChk("R2 idle read");
    end

    // R1: output enable high during busy
    arrayData = 8'hFF;
    startOp(1'b0, 8'h00);
    ceN = 1'b0; oeN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 oeN high", rdData, 8'h00);
    ceN = 1'b1; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 ceN high", rdData, 8'h00);
    oeN = 1'b1;
    @(posedge clk); @(negedge clk);

    // R8: second start while busy ignored
    repeat (3) @(negedge clk);
    opStart = 1'b1; opIsErase = 1'b1; loadData = 8'h80;
    @(posedge clk); @(negedge clk);
    opStart = 1'b0;
    readChk("R8 type and bit kept");
    check("R8 bit7 still program poll", {7'd0, rdData[7]}, 8'd0);
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 bit7 program poll", {7'd0, rdData[7]}, 8'd1);
    ceN = 1'b1; oeN = 1'b1;
    waitIdle();
    check("R8 length unchanged", 8'(busyCnt), 8'(PC));

    // R10: no toggle after completion
    arrayData = 8'h55;
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    b6 = rdData[6];
    check("R10 first idle read", rdData, 8'h55);
    ceN = 1'b1; oeN = 1'b1;
    @(posedge clk); @(negedge clk);
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 bit6 steady", {7'd0, rdData[6]}, {7'd0, b6});
    ceN = 1'b1; oeN = 1'b1;
    @(posedge clk); @(negedge clk);

    // R6: toggle state across successive reads, then R9 reset mid-operation
    arrayData = 8'h00;
    startOp(1'b1, 8'h00);
    readChk("R6 read a");
    readChk("R6 read b");
    #2 rstN = 1'b0;
    #1 check("R9 async busy release", {7'd0, busyN}, 8'd1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startOp(1'b0, 8'h7F);
    ceN = 1'b0; oeN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 toggle cleared, first read", rdData, 8'hC0);
    ceN = 1'b1; oeN = 1'b1;
    @(posedge clk); @(negedge clk);
    readChk("R6 after reset");
    waitIdle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule